// File: doc/BRIEF.md
# Extended-Precision Widening Converter

This block turns a 32-bit single-precision or 64-bit double-precision binary floating-point value into the 80-bit double extended-precision format. The wider format stores its integer bit explicitly, so every source value maps exactly and no rounding stage exists. A third selection passes an 80-bit operand through untouched, which lets a load path feed all three operand sizes through one register.

Alongside the value, the converter reports two conditions of the source. It flags an invalid operation when a narrow signaling NaN is seen, and it flags a denormal source. A denormal mask input decides whether the denormal condition also becomes a pending trap. Neither condition ever suppresses the result: the widened value is always written and marked valid. The result, flags and valid bit appear one clock after the input is presented.

Top module: `fext_widen`

## Requirements
- R1: With `in_fmt` = 2'b00 the source is `in_data[31:0]`. A normal single value gives exponent e - 127 + 16383 in result bits 78:64, the sign in bit 79, an integer bit of 1 in bit 63, and the 23 fraction bits in 62:40 with zeros below.
- R2: With `in_fmt` = 2'b01 the source is `in_data[63:0]`. A normal double value gives exponent e - 1023 + 16383, an integer bit of 1, and the 52 fraction bits in 62:11 with zeros below.
- R3: A narrow zero keeps its sign and gives exponent 0, integer bit 0 and fraction 0.
- R4: A narrow infinity keeps its sign and gives exponent 0x7FFF, integer bit 1 and fraction 0.
- R5: A narrow NaN gives exponent 0x7FFF, integer bit 1, and its payload left-aligned under the integer bit, with bit 62 forced to 1. When the source NaN was signaling (top fraction bit 0), `out_flag_inv` is 1; otherwise it is 0.
- R6: A narrow denormal is normalized: its leading one becomes the integer bit, the bits below it follow, and the exponent is 16383 - bias - z, where z counts the zeros above the leading one in the source fraction. `out_flag_den` is 1 for such a value.
- R7: With `in_fmt[1]` = 1 (2'b10, and 2'b11 treated alike) the 80-bit `in_data` appears unchanged on `out_data`, and both flags are 0, even for signaling NaN or denormal patterns.
- R8: `out_den_trap` is 1 exactly when `out_flag_den` is 1 and the `dnorm_mask` sampled with that input was 0; in that case the converted value is still produced and `out_valid` is still 1.
- R9: `out_valid` is `in_valid` delayed by one clock; in a cycle where `in_valid` is 0, `out_data` and all flags keep their previous values.
- R10: While `rst_n` is low, `out_valid`, `out_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 2 | Source size: 00 single, 01 double, 1x extended |
| in_data | input | 80 | Source operand, right-aligned |
| dnorm_mask | input | 1 | 1 masks the denormal trap |
| out_valid | output | 1 | Result valid |
| out_data | output | 80 | Extended-precision result |
| out_flag_inv | output | 1 | Signaling NaN seen in a narrow source |
| out_flag_den | output | 1 | Denormal seen in a narrow source |
| out_den_trap | output | 1 | Denormal flag with trap unmasked |

## Verification
The bench builds the converter with its default field widths for the single and double paths (8/23 and 11/52), the only settings the formats admit. Those widths let sweeps of a single set bit cover every count of the leading-zero logic in both denormal paths, from the smallest denormal to the largest. The reference model normalizes by shifting one place at a time, so any error in the counted shift or exponent adjustment shows at once.

// File: rtl/fext_pkg.sv
package fext_pkg;
  localparam int XEXP_W = 15;
  localparam int XMAN_W = 64;
  localparam int XBIAS  = 16383;
  localparam int XW     = 1 + XEXP_W + XMAN_W;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_EXT = 2'b10,
    FMT_RSV = 2'b11
  } fext_fmt_e;

  typedef struct packed {
    logic                sign;
    logic [XEXP_W-1:0]   exp;
    logic [XMAN_W-1:0]   man;
  } fext_x80_t;
endpackage

// File: rtl/fext_lzc.sv
module fext_lzc #(
  parameter int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fext_unpack.sv
module fext_unpack
  import fext_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23,
  localparam int SW   = 1 + EW + FW,
  localparam int BIAS = (1 << (EW - 1)) - 1,
  localparam int OFS  = XBIAS - BIAS,
  localparam int LZW  = $clog2(FW + 1)
) (
  input  logic [SW-1:0] src,
  output fext_x80_t     wide,
  output logic          snan,
  output logic          denorm
);
  logic [EW-1:0]     e_fld;
  logic [FW-1:0]     f_fld;
  logic              e_max, e_min, f_nz;
  logic [LZW-1:0]    lz;
  logic [XMAN_W-1:0] aligned;
  logic [6:0]        shamt;

  assign e_fld   = src[SW-2:FW];
  assign f_fld   = src[FW-1:0];
  assign e_max   = &e_fld;
  assign e_min   = ~|e_fld;
  assign f_nz    = |f_fld;
  assign aligned = {1'b0, f_fld, {(XMAN_W-1-FW){1'b0}}};
  assign shamt   = 7'(lz) + 7'd1;

  fext_lzc #(.W(FW)) u_lzc (
    .vec   (f_fld),
    .zeros (lz)
  );

  always_comb begin
    wide.sign = src[SW-1];
    snan      = 1'b0;
    denorm    = 1'b0;
    if (e_max) begin
      wide.exp = '1;
      if (f_nz) begin
        snan     = ~f_fld[FW-1];
        wide.man = aligned | {2'b11, {(XMAN_W-2){1'b0}}};
      end else begin
        wide.man = {1'b1, {(XMAN_W-1){1'b0}}};
      end
    end else if (e_min) begin
      if (f_nz) begin
        denorm   = 1'b1;
        wide.exp = XEXP_W'(OFS) - XEXP_W'(lz);
        wide.man = aligned << shamt;
      end else begin
        wide.exp = '0;
        wide.man = '0;
      end
    end else begin
      wide.exp = XEXP_W'(e_fld) + XEXP_W'(OFS);
      wide.man = aligned | {1'b1, {(XMAN_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fext_widen.sv
module fext_widen
  import fext_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_fmt,
  input  logic [79:0]   in_data,
  input  logic          dnorm_mask,
  output logic          out_valid,
  output logic [79:0]   out_data,
  output logic          out_flag_inv,
  output logic          out_flag_den,
  output logic          out_den_trap
);
  fext_x80_t sgl_w, dbl_w;
  logic      sgl_snan, sgl_den, dbl_snan, dbl_den;

  logic [XW-1:0] nx_data;
  logic          nx_inv, nx_den, nx_trap;

  logic [XW-1:0] data_q;
  logic          valid_q, inv_q, den_q, trap_q;

  fext_unpack #(.EW(8), .FW(23)) u_sgl (
    .src    (in_data[31:0]),
    .wide   (sgl_w),
    .snan   (sgl_snan),
    .denorm (sgl_den)
  );

  fext_unpack #(.EW(11), .FW(52)) u_dbl (
    .src    (in_data[63:0]),
    .wide   (dbl_w),
    .snan   (dbl_snan),
    .denorm (dbl_den)
  );

  // Next-state selection by source format
  always_comb begin
    unique case (fext_fmt_e'(in_fmt))
      FMT_SGL: begin
        nx_data = sgl_w;
        nx_inv  = sgl_snan;
        nx_den  = sgl_den;
      end
      FMT_DBL: begin
        nx_data = dbl_w;
        nx_inv  = dbl_snan;
        nx_den  = dbl_den;
      end
      default: begin
        nx_data = in_data;
        nx_inv  = 1'b0;
        nx_den  = 1'b0;
      end
    endcase
    nx_trap = nx_den & ~dnorm_mask;
  end

  // Result register, loaded under in_valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      inv_q   <= 1'b0;
      den_q   <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        data_q <= nx_data;
        inv_q  <= nx_inv;
        den_q  <= nx_den;
        trap_q <= nx_trap;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign out_flag_inv = inv_q;
  assign out_flag_den = den_q;
  assign out_den_trap = trap_q;
endmodule

module fext_widen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_fmt,
  input logic [79:0] in_data,
  input logic        out_valid,
  input logic [79:0] out_data,
  input logic        out_flag_inv,
  input logic        out_flag_den,
  input logic        out_den_trap
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_flag_inv) && $stable(out_flag_den)));
  assert_ext_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fmt[1]) |=> (out_data == $past(in_data) && !out_flag_inv && !out_flag_den));
  assert_trap_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_den_trap |-> out_flag_den);
  assert_inv_is_quiet_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_inv |-> (out_data[78:64] == 15'h7FFF && out_data[63] && out_data[62]));
  assert_den_normalized_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_den |-> (out_data[63] && out_data[78:64] != 15'h0));
endmodule

bind fext_widen fext_widen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_fmt       (in_fmt),
  .in_data      (in_data),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_flag_inv (out_flag_inv),
  .out_flag_den (out_flag_den),
  .out_den_trap (out_den_trap)
);

// File: tb/fext_widen_tb.sv
`timescale 1ns/1ps
module fext_widen_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_fmt;
  logic [79:0] in_data;
  logic        dnorm_mask;
  logic        out_valid;
  logic [79:0] out_data;
  logic        out_flag_inv, out_flag_den, out_den_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        exp_valid;
  logic [79:0] exp_data;
  logic [2:0]  exp_flags;

  fext_widen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_data(in_data), .dnorm_mask(dnorm_mask), .out_valid(out_valid),
    .out_data(out_data), .out_flag_inv(out_flag_inv),
    .out_flag_den(out_flag_den), .out_den_trap(out_den_trap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural model: returns {trap, den, inv, result}
  function automatic logic [82:0] ref_conv(input logic [1:0] fmt,
                                           input logic [79:0] d,
                                           input logic msk);
    int ew, fw, bias, x;
    logic [63:0] raw, e, f, m, emax;
    logic sgn, inv, den;
    if (fmt[1]) return {3'b000, d};
    if (fmt == 2'b00) begin
      ew = 8; fw = 23; bias = 127; raw = {32'd0, d[31:0]};
    end else begin
      ew = 11; fw = 52; bias = 1023; raw = d[63:0];
    end
    emax = (64'd1 << ew) - 64'd1;
    e    = (raw >> fw) & emax;
    f    = raw & ((64'd1 << fw) - 64'd1);
    sgn  = raw[ew + fw];
    inv  = 1'b0;
    den  = 1'b0;
    m    = f << (63 - fw);
    if (e == emax) begin
      x = 32767;
      if (f == 0) m = 64'h8000_0000_0000_0000;
      else begin
        inv = (f[fw-1] == 1'b0);
        m   = m | 64'hC000_0000_0000_0000;
      end
    end else if (e == 0) begin
      if (f == 0) begin
        x = 0; m = 64'd0;
      end else begin
        den = 1'b1;
        x   = 16383 + 1 - bias;
        while (m[63] == 1'b0) begin
          m = m << 1;
          x = x - 1;
        end
      end
    end else begin
      x = int'(e) - bias + 16383;
      m = m | 64'h8000_0000_0000_0000;
    end
    return {den & ~msk, den, inv, sgn, x[14:0], m};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // One clock: compare current outputs, then drive the next input
  task automatic step(input logic v, input logic [1:0] fmt,
                      input logic [79:0] d, input logic msk, input string req);
    logic [82:0] r;
    @(negedge clk);
    chk(req, "valid", {79'd0, out_valid}, {79'd0, exp_valid});
    chk(req, "data", out_data, exp_data);
    chk(req, "flags", {77'd0, out_den_trap, out_flag_den, out_flag_inv},
        {77'd0, exp_flags});
    exp_valid = v;
    if (v) begin
      r = ref_conv(fmt, d, msk);
      exp_data  = r[79:0];
      exp_flags = r[82:80];
    end
    in_valid   = v;
    in_fmt     = fmt;
    in_data    = d;
    dnorm_mask = msk;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = 2'b00; in_data = '0; dnorm_mask = 1'b1;
    exp_valid = 1'b0; exp_data = '0; exp_flags = 3'b000;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "valid", {79'd0, out_valid}, 80'd0);
    chk("R10", "data", out_data, 80'd0);
    chk("R10", "flags", {77'd0, out_den_trap, out_flag_den, out_flag_inv}, 80'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 single normals
    step(1, 2'b00, 80'h3F80_0000, 1, "R1");
    step(1, 2'b00, 80'hC0490FDB, 1, "R1");
    step(1, 2'b00, 80'h7F7F_FFFF, 1, "R1");
    step(1, 2'b00, 80'h0080_0000, 1, "R1");
    // R2 double normals
    step(1, 2'b01, 80'hC004_0000_0000_0000, 1, "R2");
    step(1, 2'b01, 80'h0010_0000_0000_0000, 1, "R2");
    step(1, 2'b01, 80'h7FEF_FFFF_FFFF_FFFF, 1, "R2");
    // R3 zeros
    step(1, 2'b00, 80'h8000_0000, 0, "R3");
    step(1, 2'b01, 80'h0, 0, "R3");
    step(1, 2'b01, 80'h8000_0000_0000_0000, 0, "R3");
    // R4 infinities
    step(1, 2'b00, 80'h7F80_0000, 0, "R4");
    step(1, 2'b01, 80'hFFF0_0000_0000_0000, 0, "R4");
    // R5 NaNs
    step(1, 2'b00, 80'h7F80_0001, 0, "R5");
    step(1, 2'b00, 80'hFFC0_1234, 0, "R5");
    step(1, 2'b01, 80'h7FF0_0000_0000_0001, 0, "R5");
    step(1, 2'b01, 80'h7FF8_0000_0000_0ABC, 0, "R5");
    // R6 / R8 denormals, masked and unmasked
    step(1, 2'b00, 80'h0000_0001, 1, "R6");
    step(1, 2'b00, 80'h807F_FFFF, 0, "R8");
    step(1, 2'b01, 80'h0000_0000_0000_0001, 0, "R8");
    step(1, 2'b01, 80'h800F_FFFF_FFFF_FFFF, 1, "R6");
    for (int i = 0; i < 23; i++)
      step(1, 2'b00, 80'(64'd1 << i), i[0], "R6");
    for (int i = 0; i < 52; i++)
      step(1, 2'b01, 80'(64'd1 << i) | 80'(i[0] ? 64'h8000_0000_0000_0000 : 64'd0), i[1], "R6");
    // R7 extended pass-through, including snan and denormal patterns
    step(1, 2'b10, 80'h7FFF_8000_0000_0000_0001, 0, "R7");
    step(1, 2'b10, 80'h0000_0000_0000_0000_0001, 0, "R7");
    step(1, 2'b11, 80'hC00A_DEAD_BEEF_0123_4567, 0, "R7");
    step(1, 2'b10, 80'h0000_0000_7F80_0001, 0, "R7");
    // R9 idle cycles hold the result, then back-to-back
    step(1, 2'b00, 80'h0000_0003, 0, "R9");
    step(0, 2'b01, 80'h7FF0_0000_0000_0001, 0, "R9");
    step(0, 2'b00, 80'h1234_5678, 1, "R9");
    step(1, 2'b01, 80'h3FF0_0000_0000_0000, 1, "R9");
    step(1, 2'b00, 80'h0040_0000, 0, "R9");
    step(0, 2'b00, 80'h0, 0, "R9");
    step(0, 2'b00, 80'h0, 0, "R9");
    finish_run();
  end
endmodule